// File: doc/BRIEF.md
# Reset and Configuration Boot Sequencer

This block governs how the device leaves its fundamental reset. Once the active-low fundamental reset is released (and resynchronised to the core clock), the sequencer latches a three-bit boot mode and a halt strap. In the plain mode it releases the core straight away with default register values. In the EEPROM mode it first walks a serial EEPROM image through a word-read request/acknowledge handshake. The handshake stands in for the shared SMBus master. Each decoded record is issued as one write on a register-write port, so the loaded values replace the defaults.

The EEPROM image is a flat list of 16-bit words grouped in threes: a register address, then the upper data half, then the lower data half. An address word of all ones ends the image. When the halt strap was latched high, the sequencer finishes its procedure and parks with the core still in reset. In that parked state, writes arriving from the management path are passed to the register-write port. A write that clears the halt bit of the control register lets the core run.

Top module: `boot_seq_top`

## Requirements
- R1: Driving `fund_rst_n` low forces `core_rst_n`, `cfg_done`, `mode_err`, `rom_req` and `cfg_wr_valid` to 0 at once, without waiting for a clock edge.
- R2: With boot mode 0 and the halt strap low, `core_rst_n` and `cfg_done` go high on the third rising clock edge after `fund_rst_n` is released, and no EEPROM read is requested.
- R3: Boot mode and halt strap are latched only on the first clock edge after the synchronised reset is released. Later changes of either strap have no effect until the next fundamental reset.
- R4: In boot mode 1 the EEPROM is read one word at a time, from word address 0 upward. Each `rom_req` stays high with an unchanged `rom_addr` until `rom_ack` is seen.
- R5: In boot mode 1, the words at 3k, 3k+1 and 3k+2 form record k: register address, data bits 31:16, data bits 15:0. Each complete record produces exactly one `cfg_wr_valid` cycle carrying that address and data, in image order, while `core_rst_n` is low.
- R6: A record whose address word is 16'hFFFF ends the load. No write is issued for it, and the sequencer then either releases the core or halts.
- R7: If no terminator is found, the load ends after the word at the highest EEPROM address has been read. Any record left incomplete at that point is discarded.
- R8: Boot modes 2 to 7 behave as mode 0 and set `mode_err`, which stays set until the next fundamental reset.
- R9: With the halt strap latched high, after the optional load `cfg_done` is 1 while `core_rst_n` stays 0.
- R10: While halted, a write presented on `sw_wr_*` appears on `cfg_wr_*` in the same cycle. Writes presented while not halted produce no `cfg_wr_valid`.
- R11: While halted, a write to address `CTRL_ADDR` (default 16'h0040) whose bit `HALT_BIT` (default bit 0) is 0 raises `core_rst_n` at the next clock edge. Such a write with that bit at 1 keeps the core in reset.
- R12: Once high, `core_rst_n` stays high until the next fundamental reset, and `cfg_done` is 1 whenever `core_rst_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| fund_rst_n | input | 1 | Fundamental reset, active low, asynchronous |
| mode_strap | input | 3 | Boot mode strap: 0 plain, 1 EEPROM load, others reserved |
| halt_strap | input | 1 | Park in reset after the boot procedure |
| rom_req | output | 1 | EEPROM word read request |
| rom_addr | output | ROM_AW | EEPROM word address |
| rom_ack | input | 1 | Read acknowledge, one cycle, with data |
| rom_rdata | input | ROM_DW | EEPROM word returned with acknowledge |
| sw_wr_valid | input | 1 | Management write strobe |
| sw_wr_addr | input | ROM_DW | Management write register address |
| sw_wr_data | input | 2*ROM_DW | Management write data |
| cfg_wr_valid | output | 1 | Register write strobe |
| cfg_wr_addr | output | ROM_DW | Register write address |
| cfg_wr_data | output | 2*ROM_DW | Register write data |
| core_rst_n | output | 1 | Core reset, active low |
| cfg_done | output | 1 | Boot procedure complete |
| mode_err | output | 1 | Sticky reserved-mode flag |

## Verification
The assertions assume that the EEPROM side acknowledges only a pending request, with a single-cycle `rom_ack`, and that nothing drives the block in between fundamental resets other than the ports listed. The bench's EEPROM model meets this: it acknowledges from an array two cycles after a request and drops the acknowledge on the following cycle. The straps are set while the fundamental reset is low. Management writes are driven a little after the falling clock edge and held for one full cycle, so each write is seen at exactly one rising edge.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

  typedef enum logic [2:0] {
    ST_STRAP,
    ST_ISSUE,
    ST_WAIT,
    ST_APPLY,
    ST_HALT,
    ST_RUN
  } boot_state_e;

  typedef enum logic [1:0] {
    FLD_ADDR,
    FLD_HI,
    FLD_LO
  } rec_field_e;

  localparam logic [2:0] MODE_PLAIN  = 3'd0;
  localparam logic [2:0] MODE_EEPROM = 3'd1;

endpackage

// File: rtl/boot_rst_sync.sv
module boot_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/boot_word_reader.sv
module boot_word_reader #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_go,
  input  logic [AW-1:0] rd_addr,
  output logic          rom_req,
  output logic [AW-1:0] rom_addr,
  input  logic          rom_ack,
  input  logic [DW-1:0] rom_rdata,
  output logic          word_vld,
  output logic [DW-1:0] word
);

  logic          req_q, req_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          vld_q, vld_d;
  logic [DW-1:0] word_q, word_d;

  always_comb begin
    req_d  = req_q;
    addr_d = addr_q;
    vld_d  = 1'b0;
    word_d = word_q;
    if (rd_go) begin
      req_d  = 1'b1;
      addr_d = rd_addr;
    end else if (req_q && rom_ack) begin
      req_d  = 1'b0;
      vld_d  = 1'b1;
      word_d = rom_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      addr_q <= '0;
      vld_q  <= 1'b0;
      word_q <= '0;
    end else begin
      req_q  <= req_d;
      addr_q <= addr_d;
      vld_q  <= vld_d;
      word_q <= word_d;
    end
  end

  assign rom_req  = req_q;
  assign rom_addr = addr_q;
  assign word_vld = vld_q;
  assign word     = word_q;

endmodule

// File: rtl/boot_seq_fsm.sv
module boot_seq_fsm
  import boot_seq_pkg::*;
#(
  parameter int          ROM_AW    = 8,
  parameter int          ROM_DW    = 16,
  parameter logic [15:0] CTRL_ADDR = 16'h0040,
  parameter int          HALT_BIT  = 0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2:0]            mode_strap,
  input  logic                  halt_strap,
  input  logic                  word_vld,
  input  logic [ROM_DW-1:0]     word,
  output logic                  rd_go,
  output logic [ROM_AW-1:0]     rd_addr,
  input  logic                  sw_wr_valid,
  input  logic [ROM_DW-1:0]     sw_wr_addr,
  input  logic [2*ROM_DW-1:0]   sw_wr_data,
  output logic                  cfg_wr_valid,
  output logic [ROM_DW-1:0]     cfg_wr_addr,
  output logic [2*ROM_DW-1:0]   cfg_wr_data,
  output logic                  core_rst_n,
  output logic                  cfg_done,
  output logic                  mode_err
);

  localparam logic [ROM_DW-1:0] END_MARK  = '1;
  localparam logic [ROM_AW-1:0] LAST_WORD = '1;
  localparam logic [ROM_DW-1:0] CTRL_A    = CTRL_ADDR[ROM_DW-1:0];

  boot_state_e         state_q, state_d, fin_st;
  rec_field_e          fld_q, fld_d;
  logic                halt_q, halt_d;
  logic [ROM_AW-1:0]   ptr_q, ptr_d;
  logic [ROM_DW-1:0]   rec_addr_q, rec_addr_d;
  logic [ROM_DW-1:0]   rec_hi_q, rec_hi_d;
  logic [ROM_DW-1:0]   rec_lo_q, rec_lo_d;
  logic                err_q, err_d;
  logic                run_q, run_d;
  logic                done_q, done_d;
  logic                ctrl_release;

  assign fin_st       = halt_q ? ST_HALT : ST_RUN;
  assign ctrl_release = sw_wr_valid && (sw_wr_addr == CTRL_A) && !sw_wr_data[HALT_BIT];

  always_comb begin
    state_d    = state_q;
    fld_d      = fld_q;
    halt_d     = halt_q;
    ptr_d      = ptr_q;
    rec_addr_d = rec_addr_q;
    rec_hi_d   = rec_hi_q;
    rec_lo_d   = rec_lo_q;
    err_d      = err_q;
    rd_go      = 1'b0;
    unique case (state_q)
      ST_STRAP: begin
        halt_d = halt_strap;
        if (mode_strap == MODE_EEPROM) begin
          state_d = ST_ISSUE;
        end else begin
          err_d   = err_q | (mode_strap != MODE_PLAIN);
          state_d = halt_strap ? ST_HALT : ST_RUN;
        end
      end
      ST_ISSUE: begin
        rd_go   = 1'b1;
        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (word_vld) begin
          ptr_d = ptr_q + 1'b1;
          unique case (fld_q)
            FLD_ADDR: begin
              if (word == END_MARK) begin
                state_d = fin_st;
              end else begin
                rec_addr_d = word;
                fld_d      = FLD_HI;
                state_d    = (ptr_q == LAST_WORD) ? fin_st : ST_ISSUE;
              end
            end
            FLD_HI: begin
              rec_hi_d = word;
              fld_d    = FLD_LO;
              state_d  = (ptr_q == LAST_WORD) ? fin_st : ST_ISSUE;
            end
            FLD_LO: begin
              rec_lo_d = word;
              fld_d    = FLD_ADDR;
              state_d  = ST_APPLY;
            end
            default: begin
              fld_d = FLD_ADDR;
            end
          endcase
        end
      end
      ST_APPLY: begin
        state_d = (ptr_q == '0) ? fin_st : ST_ISSUE;
      end
      ST_HALT: begin
        if (ctrl_release) begin
          halt_d  = 1'b0;
          state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        state_d = ST_RUN;
      end
      default: begin
        state_d = ST_STRAP;
      end
    endcase
    run_d  = (state_d == ST_RUN);
    done_d = (state_d == ST_RUN) || (state_d == ST_HALT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_STRAP;
      fld_q      <= FLD_ADDR;
      halt_q     <= 1'b0;
      ptr_q      <= '0;
      rec_addr_q <= '0;
      rec_hi_q   <= '0;
      rec_lo_q   <= '0;
      err_q      <= 1'b0;
      run_q      <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      fld_q      <= fld_d;
      halt_q     <= halt_d;
      ptr_q      <= ptr_d;
      rec_addr_q <= rec_addr_d;
      rec_hi_q   <= rec_hi_d;
      rec_lo_q   <= rec_lo_d;
      err_q      <= err_d;
      run_q      <= run_d;
      done_q     <= done_d;
    end
  end

  always_comb begin
    if (state_q == ST_HALT) begin
      cfg_wr_valid = sw_wr_valid;
      cfg_wr_addr  = sw_wr_addr;
      cfg_wr_data  = sw_wr_data;
    end else begin
      cfg_wr_valid = (state_q == ST_APPLY);
      cfg_wr_addr  = rec_addr_q;
      cfg_wr_data  = {rec_hi_q, rec_lo_q};
    end
  end

  assign rd_addr    = ptr_q;
  assign core_rst_n = run_q;
  assign cfg_done   = done_q;
  assign mode_err   = err_q;

endmodule

// File: rtl/boot_seq_top.sv
module boot_seq_top #(
  parameter int          ROM_AW      = 8,
  parameter int          ROM_DW      = 16,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] CTRL_ADDR   = 16'h0040,
  parameter int          HALT_BIT    = 0
) (
  input  logic                clk,
  input  logic                fund_rst_n,
  input  logic [2:0]          mode_strap,
  input  logic                halt_strap,
  output logic                rom_req,
  output logic [ROM_AW-1:0]   rom_addr,
  input  logic                rom_ack,
  input  logic [ROM_DW-1:0]   rom_rdata,
  input  logic                sw_wr_valid,
  input  logic [ROM_DW-1:0]   sw_wr_addr,
  input  logic [2*ROM_DW-1:0] sw_wr_data,
  output logic                cfg_wr_valid,
  output logic [ROM_DW-1:0]   cfg_wr_addr,
  output logic [2*ROM_DW-1:0] cfg_wr_data,
  output logic                core_rst_n,
  output logic                cfg_done,
  output logic                mode_err
);

  logic              srst_n;
  logic              rd_go;
  logic [ROM_AW-1:0] rd_addr;
  logic              word_vld;
  logic [ROM_DW-1:0] word;

  boot_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .arst_n (fund_rst_n),
    .srst_n (srst_n)
  );

  boot_word_reader #(
    .AW (ROM_AW),
    .DW (ROM_DW)
  ) u_reader (
    .clk       (clk),
    .rst_n     (srst_n),
    .rd_go     (rd_go),
    .rd_addr   (rd_addr),
    .rom_req   (rom_req),
    .rom_addr  (rom_addr),
    .rom_ack   (rom_ack),
    .rom_rdata (rom_rdata),
    .word_vld  (word_vld),
    .word      (word)
  );

  boot_seq_fsm #(
    .ROM_AW    (ROM_AW),
    .ROM_DW    (ROM_DW),
    .CTRL_ADDR (CTRL_ADDR),
    .HALT_BIT  (HALT_BIT)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (srst_n),
    .mode_strap   (mode_strap),
    .halt_strap   (halt_strap),
    .word_vld     (word_vld),
    .word         (word),
    .rd_go        (rd_go),
    .rd_addr      (rd_addr),
    .sw_wr_valid  (sw_wr_valid),
    .sw_wr_addr   (sw_wr_addr),
    .sw_wr_data   (sw_wr_data),
    .cfg_wr_valid (cfg_wr_valid),
    .cfg_wr_addr  (cfg_wr_addr),
    .cfg_wr_data  (cfg_wr_data),
    .core_rst_n   (core_rst_n),
    .cfg_done     (cfg_done),
    .mode_err     (mode_err)
  );

endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk #(
  parameter int ROM_AW = 8
) (
  input logic              clk,
  input logic              fund_rst_n,
  input logic              rom_req,
  input logic [ROM_AW-1:0] rom_addr,
  input logic              rom_ack,
  input logic              cfg_wr_valid,
  input logic              core_rst_n,
  input logic              cfg_done,
  input logic              mode_err
);

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!fund_rst_n)
    (rom_req && !rom_ack) |=> rom_req);

  // R4
  addr_stable_chk: assert property (@(posedge clk) disable iff (!fund_rst_n)
    (rom_req && !rom_ack) |=> $stable(rom_addr));

  // R5
  write_in_reset_chk: assert property (@(posedge clk) disable iff (!fund_rst_n)
    cfg_wr_valid |-> !core_rst_n);

  // R12
  core_sticky_chk: assert property (@(posedge clk) disable iff (!fund_rst_n)
    core_rst_n |=> core_rst_n);

  // R12
  done_with_core_chk: assert property (@(posedge clk) disable iff (!fund_rst_n)
    core_rst_n |-> cfg_done);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!fund_rst_n)
    mode_err |=> mode_err);

  // R4
  no_read_after_boot_chk: assert property (@(posedge clk) disable iff (!fund_rst_n)
    core_rst_n |-> !rom_req);

endmodule

bind boot_seq_top boot_seq_chk #(
  .ROM_AW (ROM_AW)
) u_chk (
  .clk          (clk),
  .fund_rst_n   (fund_rst_n),
  .rom_req      (rom_req),
  .rom_addr     (rom_addr),
  .rom_ack      (rom_ack),
  .cfg_wr_valid (cfg_wr_valid),
  .core_rst_n   (core_rst_n),
  .cfg_done     (cfg_done),
  .mode_err     (mode_err)
);

// File: tb/boot_seq_top_tb.sv
module boot_seq_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int NWORDS = 1 << AW;
  localparam logic [15:0] CTRL = 16'h0040;

  // vector: [8:6] mode, [5] halt, [4] expected mode_err, [3:0] expected writes
  localparam int NVEC = 6;
  localparam logic [8:0] VEC [NVEC] = '{
    {3'd0, 1'b0, 1'b0, 4'd0},
    {3'd1, 1'b0, 1'b0, 4'd3},
    {3'd2, 1'b0, 1'b1, 4'd0},
    {3'd7, 1'b0, 1'b1, 4'd0},
    {3'd1, 1'b1, 1'b0, 4'd3},
    {3'd0, 1'b1, 1'b0, 4'd0}
  };

  logic          clk;
  logic          fund_rst_n;
  logic [2:0]    mode_strap;
  logic          halt_strap;
  logic          rom_req;
  logic [AW-1:0] rom_addr;
  logic          rom_ack;
  logic [DW-1:0] rom_rdata;
  logic          sw_wr_valid;
  logic [DW-1:0] sw_wr_addr;
  logic [31:0]   sw_wr_data;
  logic          cfg_wr_valid;
  logic [DW-1:0] cfg_wr_addr;
  logic [31:0]   cfg_wr_data;
  logic          core_rst_n;
  logic          cfg_done;
  logic          mode_err;

  boot_seq_top u_dut (
    .clk          (clk),
    .fund_rst_n   (fund_rst_n),
    .mode_strap   (mode_strap),
    .halt_strap   (halt_strap),
    .rom_req      (rom_req),
    .rom_addr     (rom_addr),
    .rom_ack      (rom_ack),
    .rom_rdata    (rom_rdata),
    .sw_wr_valid  (sw_wr_valid),
    .sw_wr_addr   (sw_wr_addr),
    .sw_wr_data   (sw_wr_data),
    .cfg_wr_valid (cfg_wr_valid),
    .cfg_wr_addr  (cfg_wr_addr),
    .cfg_wr_data  (cfg_wr_data),
    .core_rst_n   (core_rst_n),
    .cfg_done     (cfg_done),
    .mode_err     (mode_err)
  );

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  logic [DW-1:0] rom_mem [NWORDS];
  int            lat;
  int            rd_cnt;
  logic [AW-1:0] rd_log [NWORDS];
  int            wr_cnt;
  logic [DW-1:0] wa_log [128];
  logic [31:0]   wd_log [128];

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // EEPROM model: acknowledge two cycles after a request, one-cycle pulse
  always @(negedge clk) begin
    if (!fund_rst_n) begin
      rom_ack <= 1'b0;
      lat     <= 0;
      rd_cnt  <= 0;
    end else if (rom_ack) begin
      rom_ack <= 1'b0;
    end else if (rom_req) begin
      if (lat == 1) begin
        rom_ack   <= 1'b1;
        rom_rdata <= rom_mem[rom_addr];
        if (rd_cnt < NWORDS) rd_log[rd_cnt] <= rom_addr;
        rd_cnt <= rd_cnt + 1;
        lat    <= 0;
      end else begin
        lat <= lat + 1;
      end
    end
  end

  // register-write monitor
  always @(negedge clk) begin
    if (!fund_rst_n) begin
      wr_cnt <= 0;
    end else if (cfg_wr_valid) begin
      if (wr_cnt < 128) begin
        wa_log[wr_cnt] <= cfg_wr_addr;
        wd_log[wr_cnt] <= cfg_wr_data;
      end
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic image_std();
    for (int i = 0; i < NWORDS; i++) rom_mem[i] = 16'h0000;
    rom_mem[0] = 16'h0010; rom_mem[1] = 16'h1111; rom_mem[2] = 16'h2222;
    rom_mem[3] = 16'h0024; rom_mem[4] = 16'hA5A5; rom_mem[5] = 16'h5A5A;
    rom_mem[6] = 16'h0100; rom_mem[7] = 16'hDEAD; rom_mem[8] = 16'hBEEF;
    rom_mem[9] = 16'hFFFF;
  endtask

  task automatic image_noterm();
    for (int i = 0; i < NWORDS; i++) rom_mem[i] = 16'h0100 + 16'(i);
  endtask

  task automatic do_reset(input logic [2:0] m, input logic h);
    @(negedge clk);
    fund_rst_n = 1'b0;
    mode_strap = m;
    halt_strap = h;
    repeat (3) @(negedge clk);
    fund_rst_n = 1'b1;
  endtask

  task automatic wait_done(input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (cfg_done) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic sw_write(input logic [15:0] a, input logic [31:0] d,
                          output logic fv, output logic [15:0] fa, output logic [31:0] fd);
    @(negedge clk);
    #2;
    sw_wr_valid = 1'b1;
    sw_wr_addr  = a;
    sw_wr_data  = d;
    #1;
    fv = cfg_wr_valid;
    fa = cfg_wr_addr;
    fd = cfg_wr_data;
    @(negedge clk);
    #2;
    sw_wr_valid = 1'b0;
  endtask

  task automatic check_std_writes(input string tag);
    chk({tag, " wr0 addr"}, 32'(wa_log[0]), 32'h0010);
    chk({tag, " wr0 data"}, wd_log[0], 32'h1111_2222);
    chk({tag, " wr1 addr"}, 32'(wa_log[1]), 32'h0024);
    chk({tag, " wr1 data"}, wd_log[1], 32'hA5A5_5A5A);
    chk({tag, " wr2 addr"}, 32'(wa_log[2]), 32'h0100);
    chk({tag, " wr2 data"}, wd_log[2], 32'hDEAD_BEEF);
  endtask

  // watchdog
  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=done", cycles);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic          fv;
    logic [15:0]   fa;
    logic [31:0]   fd;
    fund_rst_n  = 1'b0;
    mode_strap  = 3'd0;
    halt_strap  = 1'b0;
    sw_wr_valid = 1'b0;
    sw_wr_addr  = '0;
    sw_wr_data  = '0;
    rom_rdata   = '0;
    image_std();
    repeat (3) @(negedge clk);

    // R1: reset state
    chk("R1 reset core_rst_n", 32'(core_rst_n), 32'd0);
    chk("R1 reset cfg_done", 32'(cfg_done), 32'd0);
    chk("R1 reset mode_err", 32'(mode_err), 32'd0);
    chk("R1 reset rom_req", 32'(rom_req), 32'd0);

    // vector table: R5 R6 R8 R9 R11
    for (int v = 0; v < NVEC; v++) begin
      image_std();
      do_reset(VEC[v][8:6], VEC[v][5]);
      wait_done(500);
      chk($sformatf("R9 vec%0d cfg_done", v), 32'(cfg_done), 32'd1);
      chk($sformatf("R9 vec%0d core_rst_n", v), 32'(core_rst_n), 32'(!VEC[v][5]));
      chk($sformatf("R8 vec%0d mode_err", v), 32'(mode_err), 32'(VEC[v][4]));
      chk($sformatf("R6 vec%0d write count", v), 32'(wr_cnt), 32'(VEC[v][3:0]));
      if (VEC[v][3:0] == 4'd3) check_std_writes($sformatf("R5 vec%0d", v));
      if (VEC[v][5]) begin
        sw_write(CTRL, 32'h0000_0002, fv, fa, fd);
        @(negedge clk);
        chk($sformatf("R11 vec%0d release", v), 32'(core_rst_n), 32'd1);
      end
    end

    // R2: exact release timing in mode 0
    image_std();
    do_reset(3'd0, 1'b0);
    @(negedge clk);
    @(negedge clk);
    chk("R2 core held after 2 edges", 32'(core_rst_n), 32'd0);
    @(negedge clk);
    chk("R2 core released on 3rd edge", 32'(core_rst_n), 32'd1);
    chk("R2 cfg_done on 3rd edge", 32'(cfg_done), 32'd1);
    chk("R2 no EEPROM reads", 32'(rd_cnt), 32'd0);

    // R3: strap changes after sampling are ignored
    mode_strap = 3'd3;
    halt_strap = 1'b1;
    repeat (5) @(negedge clk);
    chk("R3 mode_err unchanged", 32'(mode_err), 32'd0);
    chk("R3 core stays released", 32'(core_rst_n), 32'd1);
    do_reset(3'd1, 1'b0);
    repeat (6) @(negedge clk);
    mode_strap = 3'd0;
    halt_strap = 1'b1;
    wait_done(500);
    chk("R3 load completes after strap change", 32'(wr_cnt), 32'd3);
    chk("R3 halt strap change ignored", 32'(core_rst_n), 32'd1);

    // R4: read order
    chk("R4 read count", 32'(rd_cnt), 32'd10);
    for (int i = 0; i < 10; i++)
      chk($sformatf("R4 read %0d address", i), 32'(rd_log[i]), 32'(i));

    // R1/R12: asynchronous reset after a reserved-mode run
    do_reset(3'd2, 1'b0);
    wait_done(100);
    chk("R12 core high", 32'(core_rst_n), 32'd1);
    @(negedge clk);
    #2;
    fund_rst_n = 1'b0;
    #1;
    chk("R1 async core_rst_n", 32'(core_rst_n), 32'd0);
    chk("R1 async cfg_done", 32'(cfg_done), 32'd0);
    chk("R1 async mode_err", 32'(mode_err), 32'd0);
    chk("R1 async cfg_wr_valid", 32'(cfg_wr_valid), 32'd0);

    // R7: image without terminator
    image_noterm();
    do_reset(3'd1, 1'b0);
    wait_done(5000);
    chk("R7 write count", 32'(wr_cnt), 32'd85);
    chk("R7 read count", 32'(rd_cnt), 32'd256);
    chk("R7 first addr", 32'(wa_log[0]), 32'h0100);
    chk("R7 first data", wd_log[0], 32'h0101_0102);
    chk("R7 last addr", 32'(wa_log[84]), 32'h01FC);
    chk("R7 last data", wd_log[84], 32'h01FD_01FE);
    chk("R7 core released", 32'(core_rst_n), 32'd1);

    // R10/R11: halted write path
    image_std();
    do_reset(3'd0, 1'b1);
    wait_done(100);
    sw_write(16'h0044, 32'h0000_0000, fv, fa, fd);
    chk("R10 forward valid", 32'(fv), 32'd1);
    chk("R10 forward addr", 32'(fa), 32'h0044);
    chk("R10 forward data", fd, 32'h0000_0000);
    chk("R11 other address keeps halt", 32'(core_rst_n), 32'd0);
    sw_write(CTRL, 32'hFFFF_FFFF, fv, fa, fd);
    chk("R10 forward ctrl data", fd, 32'hFFFF_FFFF);
    chk("R11 halt bit set keeps halt", 32'(core_rst_n), 32'd0);
    sw_write(CTRL, 32'hFFFF_FFFE, fv, fa, fd);
    chk("R11 halt bit clear releases", 32'(core_rst_n), 32'd1);
    sw_write(16'h0044, 32'h0000_0005, fv, fa, fd);
    chk("R10 write ignored when running", 32'(fv), 32'd0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule